// File: doc/BRIEF.md
# Differential-Pair Plasticity Instruction Sequencer

This block sits between an instruction source and the drive circuitry of an array of sixteen two-terminal adaptive devices. The devices are grouped into eight differential pairs. Pair `i` uses device `i` as its A element and device `i+8` as its B element, with zero-based device numbers. An instruction arrives with a pair index over a valid/ready handshake. The block then emits one or two primitive drive operations over a second valid/ready handshake. Each operation carries a 3-bit operation code and a 4-bit device number. A one-cycle done pulse marks the end of the instruction.

Primitive instructions pass through as a single operation. Two compound instructions, reinforce and weaken, expand into an ordered pair of operations. The choice of operations depends on the sign of `gA - gB` for the addressed pair. The block keeps per-pair copies of both conductances and refreshes them whenever a read result is returned on the read-back port. Reinforcing pushes the pair further toward its present sign, and weakening pushes it back toward zero. Repeating these two instructions drives the pair's state toward certainty or toward noise.

Top module: `dps_seq`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `op_valid` are 0 and `in_ready` is 1. All stored conductances are zero, so a compound instruction sent before any read-back treats its pair as `gA >= gB`.
- R2: `in_ready` equals `!busy`. An instruction is taken on a clock edge where `in_valid && in_ready`. Its first operation is presented with `op_valid` high in the cycle right after.
- R3: `op_dev` is `pair + 8` for the B-only operations (increase B = 3'b010, decrease B = 3'b101). It is `pair` for every other code, including read and both-element codes.
- R4: Operation codes are: read 000, increase A 001, increase B 010, increase both 011, decrease A 100, decrease B 101, decrease both 110. An instruction with bit 3 = 0 emits exactly one operation whose code is the instruction's bits 2:0, unchanged.
- R5: An instruction with bit 3 = 1 and bit 0 = 0 is reinforce. With `gA >= gB` it emits increase A then decrease B. With `gA < gB` it emits decrease A then increase B. Bits 2:1 are ignored.
- R6: An instruction with bit 3 = 1 and bit 0 = 1 is weaken. With `gA >= gB` it emits decrease A then increase B. With `gA < gB` it emits increase A then decrease B.
- R7: A read-back (`rb_valid`) overwrites the stored `gA`/`gB` of `rb_pair` only. The compound decision uses the stored values of the addressed pair at the edge the instruction is taken. Ties count as `gA >= gB`.
- R8: While `op_valid` is high and `op_ready` is low, `op_valid`, `op_code` and `op_dev` hold their values.
- R9: On the edge that accepts the final operation of an instruction, `busy` falls and `done` rises for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Instruction can be taken |
| in_instr | input | 4 | Instruction code |
| in_pair | input | 3 | Target pair index |
| rb_valid | input | 1 | Read result present |
| rb_pair | input | 3 | Pair the read result belongs to |
| rb_ga | input | 12 | Conductance of element A |
| rb_gb | input | 12 | Conductance of element B |
| op_valid | output | 1 | Operation offered to the driver |
| op_ready | input | 1 | Driver accepts the operation |
| op_code | output | 3 | Operation code |
| op_dev | output | 4 | Device number the operation drives |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle end-of-instruction pulse |

## Verification
The first operation is due one cycle after the accepting edge. Each later operation is due one cycle after the edge that accepts its predecessor. `done` is high and `busy` low in the cycle after the final acceptance, and `done` is low again one cycle later. A read-back is visible to any instruction taken at a later edge. The bench drives and samples only at falling edges and walks these steps one cycle at a time. It checks code, device, `busy` and `in_ready` in every cycle an operation waits, including randomly stalled ones. It then checks the `done` pulse in the cycle after the final hand-over and its fall one cycle later.

// File: rtl/dps_pkg.sv
package dps_pkg;

    localparam int INSTR_W = 4;

    typedef enum logic [2:0] {
        OP_READ   = 3'b000,
        OP_INC_A  = 3'b001,
        OP_INC_B  = 3'b010,
        OP_INC_AB = 3'b011,
        OP_DEC_A  = 3'b100,
        OP_DEC_B  = 3'b101,
        OP_DEC_AB = 3'b110,
        OP_RSVD   = 3'b111
    } op_e;

    typedef struct packed {
        logic two;
        op_e  first;
        op_e  second;
    } plan_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2
    } st_e;

    function automatic logic is_compound(logic [INSTR_W-1:0] ins);
        return ins[3];
    endfunction

    function automatic logic is_weaken(logic [INSTR_W-1:0] ins);
        return ins[0];
    endfunction

    function automatic logic targets_b(op_e op);
        return (op == OP_INC_B) || (op == OP_DEC_B);
    endfunction

endpackage

// File: rtl/dps_pair_store.sv
module dps_pair_store #(
    parameter int NPAIR = 8,
    parameter int GW    = 12,
    localparam int PW   = $clog2(NPAIR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rb_valid,
    input  logic [PW-1:0] rb_pair,
    input  logic [GW-1:0] rb_ga,
    input  logic [GW-1:0] rb_gb,
    input  logic [PW-1:0] rd_pair,
    output logic          rd_ge
);
    logic [GW-1:0] ga_q [NPAIR];
    logic [GW-1:0] gb_q [NPAIR];

    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        always_ff @(posedge clk) begin
            if (rst) begin
                ga_q[p] <= '0;
                gb_q[p] <= '0;
            end else if (rb_valid && (rb_pair == PW'(p))) begin
                ga_q[p] <= rb_ga;
                gb_q[p] <= rb_gb;
            end
        end
    end

    assign rd_ge = ga_q[rd_pair] >= gb_q[rd_pair];

    // R7: a returned read is held for the addressed pair
    assert_capture_R7: assert property (@(posedge clk) disable iff (rst)
        rb_valid |=> (ga_q[$past(rb_pair)] == $past(rb_ga)) &&
                     (gb_q[$past(rb_pair)] == $past(rb_gb)));
endmodule

// File: rtl/dps_expand.sv
module dps_expand
    import dps_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               ge,
    output plan_t              plan
);
    always_comb begin
        plan.two    = is_compound(instr);
        plan.first  = op_e'(instr[2:0]);
        plan.second = OP_READ;
        if (is_compound(instr)) begin
            if (ge ^ is_weaken(instr)) begin
                plan.first  = OP_INC_A;
                plan.second = OP_DEC_B;
            end else begin
                plan.first  = OP_DEC_A;
                plan.second = OP_INC_B;
            end
        end
    end
endmodule

// File: rtl/dps_seq.sv
module dps_seq
    import dps_pkg::*;
#(
    parameter int NPAIR = 8,
    parameter int GW    = 12,
    localparam int PW   = $clog2(NPAIR),
    localparam int DW   = $clog2(2 * NPAIR)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [3:0]    in_instr,
    input  logic [PW-1:0] in_pair,
    input  logic          rb_valid,
    input  logic [PW-1:0] rb_pair,
    input  logic [GW-1:0] rb_ga,
    input  logic [GW-1:0] rb_gb,
    output logic          op_valid,
    input  logic          op_ready,
    output logic [2:0]    op_code,
    output logic [DW-1:0] op_dev,
    output logic          busy,
    output logic          done
);
    st_e           st;
    plan_t         plan_d, plan_q;
    logic [PW-1:0] pair_q;
    logic          done_q;
    logic          ge;
    logic          accept;
    op_e           cur_op;

    dps_pair_store #(.NPAIR(NPAIR), .GW(GW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .rb_valid (rb_valid),
        .rb_pair  (rb_pair),
        .rb_ga    (rb_ga),
        .rb_gb    (rb_gb),
        .rd_pair  (in_pair),
        .rd_ge    (ge)
    );

    dps_expand u_expand (
        .instr (in_instr),
        .ge    (ge),
        .plan  (plan_d)
    );

    assign busy     = (st != ST_IDLE);
    assign in_ready = !busy;
    assign accept   = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            plan_q <= '0;
            pair_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (accept) begin
                        plan_q <= plan_d;
                        pair_q <= in_pair;
                        st     <= ST_FIRST;
                    end
                end
                ST_FIRST: begin
                    if (op_ready) begin
                        if (plan_q.two) begin
                            st <= ST_SECOND;
                        end else begin
                            st     <= ST_IDLE;
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_SECOND: begin
                    if (op_ready) begin
                        st     <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign cur_op   = (st == ST_SECOND) ? plan_q.second : plan_q.first;
    assign op_valid = busy;
    assign op_code  = cur_op;
    assign op_dev   = targets_b(cur_op) ? (DW'(pair_q) + DW'(NPAIR)) : DW'(pair_q);
    assign done     = done_q;

    // R2: the first operation follows the accepting edge
    assert_first_op_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> op_valid);

    // R8: a stalled operation is held unchanged
    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_ready) |=> op_valid && $stable(op_code) && $stable(op_dev));

    // R9: done lasts one cycle
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done only after an accepted operation, with busy already low
    assert_done_cause_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(op_valid && op_ready) && !busy);
endmodule

// File: tb/tb_dps_seq.sv
module tb_dps_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_instr = '0;
    logic [2:0]  in_pair = '0;
    logic        rb_valid = 1'b0;
    logic [2:0]  rb_pair = '0;
    logic [11:0] rb_ga = '0;
    logic [11:0] rb_gb = '0;
    logic        op_valid;
    logic        op_ready = 1'b0;
    logic [2:0]  op_code;
    logic [3:0]  op_dev;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    int ga_m [8];
    int gb_m [8];

    always #(CLK_PERIOD / 2) clk = ~clk;

    dps_seq dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_instr(in_instr), .in_pair(in_pair),
        .rb_valid(rb_valid), .rb_pair(rb_pair), .rb_ga(rb_ga), .rb_gb(rb_gb),
        .op_valid(op_valid), .op_ready(op_ready), .op_code(op_code), .op_dev(op_dev),
        .busy(busy), .done(done)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // Expected expansion per R4, R5, R6, R7
    function automatic int expect_ops(input logic [3:0] ins, input int ga, input int gb,
                                      output logic [2:0] o0, output logic [2:0] o1);
        logic pos;
        o1 = 3'b000;
        if (!ins[3]) begin
            o0 = ins[2:0];
            return 1;
        end
        pos = (ga >= gb);
        if (ins[0]) pos = !pos;
        if (pos) begin o0 = 3'b001; o1 = 3'b101; end
        else     begin o0 = 3'b100; o1 = 3'b010; end
        return 2;
    endfunction

    // R3 device numbering
    function automatic int expect_dev(input logic [2:0] code, input int pair);
        return (code == 3'b010 || code == 3'b101) ? pair + 8 : pair;
    endfunction

    task automatic send_rb(input int p, input int a, input int b);
        rb_valid = 1'b1; rb_pair = 3'(p); rb_ga = 12'(a); rb_gb = 12'(b);
        @(negedge clk);
        rb_valid = 1'b0;
        ga_m[p] = a; gb_m[p] = b;
    endtask

    task automatic run_instr(input logic [3:0] ins, input int p, input int stall_max);
        logic [2:0] e [2];
        int n;
        n = expect_ops(ins, ga_m[p], gb_m[p], e[0], e[1]);
        chk(in_ready == 1'b1, "R2 in_ready idle", int'(in_ready), 1);
        in_valid = 1'b1; in_instr = ins; in_pair = 3'(p);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            int s;
            s = $urandom_range(0, stall_max);
            forever begin
                chk(op_valid == 1'b1, "R2/R8 op_valid", int'(op_valid), 1);
                chk(op_code == e[k], ins[3] ? (ins[0] ? "R6 code" : "R5 code") : "R4 code",
                    int'(op_code), int'(e[k]));
                chk(int'(op_dev) == expect_dev(e[k], p), "R3 device", int'(op_dev),
                    expect_dev(e[k], p));
                chk(busy && !in_ready && !done, "R2 busy", int'({busy, in_ready, done}), 4);
                op_ready = (s == 0);
                @(negedge clk);
                if (s == 0) break;
                s--;
            end
        end
        op_ready = 1'b0;
        chk(done == 1'b1, "R9 done rises", int'(done), 1);
        chk(!busy && !op_valid, "R9 busy falls", int'({busy, op_valid}), 0);
        @(negedge clk);
        chk(done == 1'b0, "R9 done one cycle", int'(done), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finished");
        report();
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        for (int i = 0; i < 8; i++) begin ga_m[i] = 0; gb_m[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk(!busy && !done && !op_valid, "R1 outputs idle", int'({busy, done, op_valid}), 0);
        chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
        // R1: zero conductances behave as gA >= gB
        run_instr(4'b1000, 3, 0);
        run_instr(4'b1001, 5, 0);
        // R7: a read on one pair leaves others alone
        send_rb(2, 5, 9);
        send_rb(4, 9, 5);
        run_instr(4'b1000, 2, 1);
        run_instr(4'b1000, 4, 1);
        run_instr(4'b1110, 0, 0);
        // R7 tie, R6 with gA < gB, R3 highest pair
        send_rb(7, 100, 100);
        run_instr(4'b1000, 7, 2);
        send_rb(7, 10, 4000);
        run_instr(4'b1001, 7, 2);
        // R4 all primitive codes, R8 stalls
        for (int c = 0; c < 8; c++) run_instr(4'(c), c, 3);
        // random mix
        for (int it = 0; it < 120; it++) begin
            if ($urandom_range(0, 9) < 4) begin
                int a;
                a = $urandom_range(0, 4095);
                send_rb($urandom_range(0, 7), a,
                        ($urandom_range(0, 3) == 0) ? a : $urandom_range(0, 4095));
            end else begin
                run_instr(4'($urandom_range(0, 15)), $urandom_range(0, 7), 3);
            end
        end
        report();
    end
endmodule